// File: doc/BRIEF.md
# Flash command interface controller

This block is the digital control core of a parallel NOR flash device, with the memory array itself left out. It watches the active-low chip enable, output enable, write enable, reset/power-down and write-protect pins. It also sees a byte/word width select and a write-lockout input that stands in for the supply-low sensing. Commands are taken from the command byte on the rising edge of write enable while the chip is selected. They choose what a read returns: array data, identifier words or the status register. They also start the altering operations (block erase, full-chip erase, program, lock-bit set and lock-bit clear), each of which takes two write cycles.

An accepted altering operation runs on an internal busy timer. The timer drives the ready/busy output low and clears the ready bit of the status register. The operation keeps running when the chip is deselected. A reset pulse long enough to pass the glitch filter aborts it and brings the interface back to its power-up state. The block drives no data pins directly. It produces the read data word and two output-enable signals, one for the low byte and one for the high byte, for the pad ring's tri-state buffers. All pins are sampled on a system clock `clk`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After an accepted reset the read mode is array. An array read returns ARRAY_WORD (default 16'hFFFF), and after command 8'h70 a read returns status 16'h0080.
- R2: dq_oe_lo and dq_oe_hi are both 0 whenever ce_n is 1, oe_n is 1 or rp_n is 0. With ce_n=0, oe_n=0 and rp_n=1, dq_oe_lo is 1.
- R3: With byte_n=0 (byte mode), dq_oe_hi is 0 while dq_oe_lo still follows R2. With byte_n=1, dq_oe_hi equals dq_oe_lo.
- R4: After command 8'h90, a read at in-block offset 0 returns MFR_ID (default 16'h00B0) and offset 1 returns DEV_ID (default 16'h00EC). Offset 2 returns the lock bit in bit 0 for the block selected by the top BLK_BITS address bits; default AW=19 and BLK_BITS=3, so block 3 offset 2 is address 19'h30002.
- R5: Driving ce_n high during an operation does not stop it. ry_by_n stays low for the operation's full busy time, then returns high with status 8'h80.
- R6: A command is taken only on a rising edge of we_n while ce_n=0. The single-cycle commands are 8'hFF (read array), 8'h90 (identifier), 8'h70 (read status) and 8'h50 (clear status); any other unrecognised opcode selects read array.
- R7: The altering sequences are: 8'h20 then 8'hD0 (block erase, T_ERASE cycles); 8'h30 then 8'hD0 (chip erase, T_CHIP); 8'h40 then any data byte (program, T_PROG); 8'h60 then 8'h01 (set the lock of the addressed block, T_LOCK); 8'h60 then 8'hD0 (clear all locks, T_LOCK). ry_by_n goes low from the cycle after the second write.
- R8: A reset is taken only once rp_n has been low for RST_MIN_CYC clocks (default 25, 100 ns). A shorter low pulse leaves a running operation to finish normally. An accepted reset aborts a running operation and keeps ry_by_n low until rp_n returns high. Lock bits reset to zero.
- R9: While rp_n is 0 no command is taken. With wlock=1 an altering sequence does not start; it sets status bit 3 and its class bit. The class bit is bit 4 for program and lock-set and bit 5 for erase and lock-clear, so a program gives status 8'h98.
- R10: With wp_n=0, program or erase of a locked block, or a chip erase while any block is locked, is refused. It sets status bit 1 and the class bit (program 8'h92, block erase 8'hA2). With wp_n=1 the lock bits do not protect.
- R11: A wrong second cycle after 8'h20, 8'h30 or 8'h60 sets status bits 5 and 4 (8'hB0), starts nothing and returns the interface to read array mode.
- R12: Status bit 7 is 1 when ready and 0 while busy. While busy every read returns status, whatever the read mode. Command 8'h50 clears bits 5, 4, 3 and 1.
- R13: Writes made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge takes a command |
| rp_n | input | 1 | Reset/power-down, active low, glitch filtered |
| wp_n | input | 1 | Write protect, active low; makes lock bits effective |
| byte_n | input | 1 | Width select: 0 byte mode, 1 word mode |
| wlock | input | 1 | Write lockout (supply-low stand-in), active high |
| addr | input | AW | Word address; top BLK_BITS bits pick the block |
| cmd_in | input | 8 | Command / data byte on the low data lines |
| dout | output | DW | Read data word for the output buffers |
| dq_oe_lo | output | 1 | Output enable for data bits 7:0 |
| dq_oe_hi | output | 1 | Output enable for data bits DW-1:8 |
| ry_by_n | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest situation to reach from the pins is a reset that lands in the middle of a running operation and passes the glitch filter. The bench must show that ry_by_n stays low across the filter window, the accepted reset and the release, and that the interface then comes back in array mode with status 80h. To get there, the stimulus starts a chip erase, the longest operation, and drops rp_n a few cycles later for well over RST_MIN_CYC clocks. It then times how quickly ry_by_n rises after release, against the much longer erase time that is left. A second case starts a program and drops rp_n for a pulse shorter than the filter. The program must then finish on its own with no abort.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RD_ARRAY = 2'd0,
      RD_IDENT = 2'd1,
      RD_STAT  = 2'd2
   } rd_mode_t;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_BERASE = 3'd1,
      SQ_CERASE = 3'd2,
      SQ_PROG   = 3'd3,
      SQ_LOCK   = 3'd4
   } seq_t;

   typedef enum logic [1:0] {
      LK_NONE = 2'd0,
      LK_SET  = 2'd1,
      LK_CLR  = 2'd2
   } lk_op_t;

   localparam logic [7:0] OPC_RD_ARRAY = 8'hFF;
   localparam logic [7:0] OPC_RD_IDENT = 8'h90;
   localparam logic [7:0] OPC_RD_STAT  = 8'h70;
   localparam logic [7:0] OPC_CLR_STAT = 8'h50;
   localparam logic [7:0] OPC_BERASE   = 8'h20;
   localparam logic [7:0] OPC_CERASE   = 8'h30;
   localparam logic [7:0] OPC_PROG     = 8'h40;
   localparam logic [7:0] OPC_LOCK     = 8'h60;
   localparam logic [7:0] OPC_CONFIRM  = 8'hD0;
   localparam logic [7:0] OPC_LSET     = 8'h01;

   // error flag vector: [3] erase class, [2] program class, [1] lockout, [0] locked block
   localparam logic [3:0] EF_ERASE = 4'b1000;
   localparam logic [3:0] EF_PROG  = 4'b0100;
   localparam logic [3:0] EF_LKOUT = 4'b0010;
   localparam logic [3:0] EF_BLOCK = 4'b0001;

endpackage

// File: rtl/fcc_rst_filter.sv
module fcc_rst_filter #(
   parameter int MIN_CYC = 25
) (
   input  logic clk,
   input  logic rp_n,
   output logic rst_acc
);
   localparam int CW = $clog2(MIN_CYC + 1);

   logic [CW-1:0] low_cnt;

   initial assert (MIN_CYC >= 2) else $error("fcc_rst_filter: MIN_CYC must be at least 2");

   always_ff @(posedge clk) begin
      if (rp_n) begin
         low_cnt <= '0;
         rst_acc <= 1'b0;
      end else if (low_cnt == CW'(MIN_CYC - 1)) begin
         rst_acc <= 1'b1;
      end else begin
         low_cnt <= low_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [TW-1:0] load,
   output logic          busy,
   output logic          done
);
   logic [TW-1:0] cnt;

   initial assert (TW >= 1) else $error("fcc_busy_timer: TW must be positive");

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (start)       cnt <= load;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == TW'(1));
endmodule

// File: rtl/fcc_cui.sv
module fcc_cui
   import flash_cmd_pkg::*;
#(
   parameter int BLK_BITS      = 3,
   parameter int TW            = 8,
   parameter int T_PROG        = 20,
   parameter int T_ERASE       = 60,
   parameter int T_CHIP        = 120,
   parameter int T_LOCK        = 30,
   parameter bit LOCK_ALL_INIT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr,
   input  logic [7:0]               cmd,
   input  logic [BLK_BITS-1:0]      blk,
   input  logic                     wlock,
   input  logic                     wp_n,
   input  logic                     tmr_busy,
   input  logic                     tmr_done,
   output logic                     tmr_start,
   output logic [TW-1:0]            tmr_load,
   output rd_mode_t                 mode,
   output logic [3:0]               errs,
   output logic [(1<<BLK_BITS)-1:0] lock
);
   localparam int NBLK = 1 << BLK_BITS;

   seq_t                seq_q, seq_d;
   rd_mode_t            mode_d;
   lk_op_t              lk_op_q, lk_op_d;
   logic [BLK_BITS-1:0] lk_blk_q;
   logic [3:0]          set_m;
   logic                clr_m;
   logic                blk_prot, any_prot;

   assign blk_prot = lock[blk] & ~wp_n;
   assign any_prot = (|lock) & ~wp_n;

   always_comb begin
      seq_d     = seq_q;
      mode_d    = mode;
      lk_op_d   = LK_NONE;
      set_m     = '0;
      clr_m     = 1'b0;
      tmr_start = 1'b0;
      tmr_load  = '0;
      if (wr && !tmr_busy) begin
         seq_d = SQ_IDLE;
         case (seq_q)
            SQ_IDLE: begin
               case (cmd)
                  OPC_RD_IDENT: mode_d = RD_IDENT;
                  OPC_RD_STAT:  mode_d = RD_STAT;
                  OPC_CLR_STAT: clr_m  = 1'b1;
                  OPC_BERASE:   begin seq_d = SQ_BERASE; mode_d = RD_STAT; end
                  OPC_CERASE:   begin seq_d = SQ_CERASE; mode_d = RD_STAT; end
                  OPC_PROG:     begin seq_d = SQ_PROG;   mode_d = RD_STAT; end
                  OPC_LOCK:     begin seq_d = SQ_LOCK;   mode_d = RD_STAT; end
                  default:      mode_d = RD_ARRAY;
               endcase
            end
            SQ_BERASE, SQ_CERASE: begin
               if (cmd != OPC_CONFIRM) begin
                  set_m  = EF_ERASE | EF_PROG;
                  mode_d = RD_ARRAY;
               end else if (wlock) begin
                  set_m = EF_ERASE | EF_LKOUT;
               end else if ((seq_q == SQ_BERASE) ? blk_prot : any_prot) begin
                  set_m = EF_ERASE | EF_BLOCK;
               end else begin
                  tmr_start = 1'b1;
                  tmr_load  = (seq_q == SQ_BERASE) ? TW'(T_ERASE) : TW'(T_CHIP);
               end
            end
            SQ_PROG: begin
               if (wlock)         set_m = EF_PROG | EF_LKOUT;
               else if (blk_prot) set_m = EF_PROG | EF_BLOCK;
               else begin
                  tmr_start = 1'b1;
                  tmr_load  = TW'(T_PROG);
               end
            end
            SQ_LOCK: begin
               if (cmd == OPC_LSET) begin
                  if (wlock) set_m = EF_PROG | EF_LKOUT;
                  else begin
                     tmr_start = 1'b1;
                     tmr_load  = TW'(T_LOCK);
                     lk_op_d   = LK_SET;
                  end
               end else if (cmd == OPC_CONFIRM) begin
                  if (wlock) set_m = EF_ERASE | EF_LKOUT;
                  else begin
                     tmr_start = 1'b1;
                     tmr_load  = TW'(T_LOCK);
                     lk_op_d   = LK_CLR;
                  end
               end else begin
                  set_m  = EF_ERASE | EF_PROG;
                  mode_d = RD_ARRAY;
               end
            end
            default: seq_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         seq_q    <= SQ_IDLE;
         mode     <= RD_ARRAY;
         errs     <= '0;
         lk_op_q  <= LK_NONE;
         lk_blk_q <= '0;
      end else begin
         seq_q <= seq_d;
         mode  <= mode_d;
         errs  <= clr_m ? '0 : (errs | set_m);
         if (tmr_start) begin
            lk_op_q  <= lk_op_d;
            lk_blk_q <= blk;
         end else if (tmr_done) begin
            lk_op_q  <= LK_NONE;
         end
      end
   end

   for (genvar g = 0; g < NBLK; g++) begin : g_lock
      always_ff @(posedge clk) begin
         if (rst)
            lock[g] <= LOCK_ALL_INIT;
         else if (tmr_done && lk_op_q == LK_CLR)
            lock[g] <= 1'b0;
         else if (tmr_done && lk_op_q == LK_SET && lk_blk_q == BLK_BITS'(g))
            lock[g] <= 1'b1;
      end
   end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int            AW            = 19,
   parameter int            DW            = 16,
   parameter int            BLK_BITS      = 3,
   parameter int            RST_MIN_CYC   = 25,
   parameter int            T_PROG        = 20,
   parameter int            T_ERASE       = 60,
   parameter int            T_CHIP        = 120,
   parameter int            T_LOCK        = 30,
   parameter bit            BYTE_MODE_EN  = 1'b1,
   parameter bit            LOCK_ALL_INIT = 1'b0,
   parameter logic [DW-1:0] MFR_ID        = 'h00B0,
   parameter logic [DW-1:0] DEV_ID        = 'h00EC,
   parameter logic [DW-1:0] ARRAY_WORD    = '1
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          rp_n,
   input  logic          wp_n,
   input  logic          byte_n,
   input  logic          wlock,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    cmd_in,
   output logic [DW-1:0] dout,
   output logic          dq_oe_lo,
   output logic          dq_oe_hi,
   output logic          ry_by_n
);
   localparam int T_M1  = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
   localparam int T_M2  = (T_CHIP > T_LOCK) ? T_CHIP : T_LOCK;
   localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
   localparam int TW    = $clog2(T_MAX + 1);
   localparam int OFS_W = AW - BLK_BITS;

   initial begin
      assert (DW >= 8) else $error("flash_cmd_ctrl: DW must be at least 8");
      assert (BLK_BITS >= 1 && OFS_W >= 2) else $error("flash_cmd_ctrl: bad block split");
      assert (T_PROG >= 1 && T_ERASE >= 1 && T_CHIP >= 1 && T_LOCK >= 1)
         else $error("flash_cmd_ctrl: operation times must be positive");
   end

   logic                     rst_acc, we_q, wr, ab_q;
   logic                     tmr_start, tmr_busy, tmr_done;
   logic [TW-1:0]            tmr_load;
   rd_mode_t                 mode, rd_sel;
   logic [3:0]               errs;
   logic [(1<<BLK_BITS)-1:0] lock;
   logic [BLK_BITS-1:0]      blk;
   logic [OFS_W-1:0]         ofs;
   logic [7:0]               sr;

   assign blk = addr[AW-1 -: BLK_BITS];
   assign ofs = addr[OFS_W-1:0];

   fcc_rst_filter #(.MIN_CYC(RST_MIN_CYC)) i_rstf (
      .clk(clk), .rp_n(rp_n), .rst_acc(rst_acc));

   always_ff @(posedge clk) we_q <= we_n;
   assign wr = we_n & ~we_q & ~ce_n & rp_n & ~rst_acc;

   fcc_busy_timer #(.TW(TW)) i_tmr (
      .clk(clk), .rst(rst_acc), .start(tmr_start), .load(tmr_load),
      .busy(tmr_busy), .done(tmr_done));

   fcc_cui #(
      .BLK_BITS(BLK_BITS), .TW(TW), .T_PROG(T_PROG), .T_ERASE(T_ERASE),
      .T_CHIP(T_CHIP), .T_LOCK(T_LOCK), .LOCK_ALL_INIT(LOCK_ALL_INIT)
   ) i_cui (
      .clk(clk), .rst(rst_acc), .wr(wr), .cmd(cmd_in), .blk(blk),
      .wlock(wlock), .wp_n(wp_n), .tmr_busy(tmr_busy), .tmr_done(tmr_done),
      .tmr_start(tmr_start), .tmr_load(tmr_load), .mode(mode), .errs(errs),
      .lock(lock));

   // abort hold: ready/busy stays low through an accepted reset that hit an operation
   always_ff @(posedge clk) begin
      if (rst_acc) ab_q <= ab_q | tmr_busy;
      else         ab_q <= 1'b0;
   end
   assign ry_by_n = ~(tmr_busy | ab_q);

   assign sr     = {~tmr_busy, 1'b0, errs[3], errs[2], errs[1], 1'b0, errs[0], 1'b0};
   assign rd_sel = tmr_busy ? RD_STAT : mode;

   always_comb begin
      case (rd_sel)
         RD_IDENT: begin
            if (ofs == OFS_W'(0))      dout = MFR_ID;
            else if (ofs == OFS_W'(1)) dout = DEV_ID;
            else if (ofs == OFS_W'(2)) dout = {{(DW-1){1'b0}}, lock[blk]};
            else                       dout = '0;
         end
         RD_STAT: dout = {{(DW-8){1'b0}}, sr};
         default: dout = ARRAY_WORD;
      endcase
   end

   assign dq_oe_lo = ~ce_n & ~oe_n & rp_n;

   if (BYTE_MODE_EN) begin : g_byte
      assign dq_oe_hi = dq_oe_lo & byte_n;
   end else begin : g_word
      assign dq_oe_hi = dq_oe_lo;
   end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
   import flash_cmd_pkg::*;
(
   input logic     clk,
   input logic     rp_n,
   input logic     we_n,
   input logic     ce_n,
   input logic     oe_n,
   input logic     wlock,
   input logic     ry_by_n,
   input logic     dq_oe_lo,
   input logic     dq_oe_hi,
   input logic     dout7,
   input logic     rst_acc,
   input logic     tmr_busy,
   input logic [7:0] stat,
   input rd_mode_t rd_mode
);
   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= seen | (rst_acc === 1'b1);

   // R2: no output enable unless both selects are active and reset is released
   a_r2_bus_hiz: assert property (@(posedge clk) disable iff (!seen)
      (ce_n || oe_n || !rp_n) |-> (!dq_oe_lo && !dq_oe_hi));

   // R1: first cycle after an accepted reset: array mode, status 80h
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!seen)
      ($past(rst_acc) && !rst_acc) |-> (stat == 8'h80 && rd_mode == RD_ARRAY));

   // R7: busy starts only right after a write-enable rising edge with chip selected
   a_r7_start_on_write: assert property (@(posedge clk) disable iff (!seen)
      $fell(ry_by_n) |-> ($past(we_n) && !$past(we_n, 2) && !$past(ce_n)));

   // R8: ready/busy stays low through an accepted reset
   a_r8_abort_hold: assert property (@(posedge clk) disable iff (!seen)
      (rst_acc && !ry_by_n) |=> !ry_by_n);

   // R9: nothing starts while write lockout is asserted
   a_r9_lockout_idle: assert property (@(posedge clk) disable iff (!seen)
      (ry_by_n && wlock && !rst_acc) |=> ry_by_n);

   // R12: a read during an operation shows the busy status bit
   a_r12_busy_stat: assert property (@(posedge clk) disable iff (!seen)
      (tmr_busy && !ce_n && !oe_n && rp_n) |-> !dout7);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk i_chk (
   .clk(clk), .rp_n(rp_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
   .wlock(wlock), .ry_by_n(ry_by_n), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
   .dout7(dout[7]), .rst_acc(rst_acc), .tmr_busy(tmr_busy), .stat(sr),
   .rd_mode(mode));

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
   localparam int AW = 19;
   localparam int DW = 16;
   localparam int T_PROG = 20, T_ERASE = 60, T_CHIP = 120, T_LOCK = 30;
   localparam logic [AW-1:0] BLK3 = 19'h30000;
   localparam logic [AW-1:0] BLK2 = 19'h20000;

   logic clk = 1'b0;
   logic ce_n, oe_n, we_n, rp_n, wp_n, byte_n, wlock;
   logic [AW-1:0] addr;
   logic [7:0]    cmd_in;
   logic [DW-1:0] dout;
   logic dq_oe_lo, dq_oe_hi, ry_by_n;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_ctrl i_flash_cmd_ctrl (
      .clk(clk), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
      .wp_n(wp_n), .byte_n(byte_n), .wlock(wlock), .addr(addr),
      .cmd_in(cmd_in), .dout(dout), .dq_oe_lo(dq_oe_lo),
      .dq_oe_hi(dq_oe_hi), .ry_by_n(ry_by_n));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; cmd_in = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d,
                     output logic lo, output logic hi);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #1;
      d = dout; lo = dq_oe_lo; hi = dq_oe_hi;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd_stat(output logic [DW-1:0] d);
      logic lo, hi;
      wr('0, 8'h70);
      rd('0, d, lo, hi);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ry_by_n && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rp_n = 1'b0;
      repeat (40) @(negedge clk);
      rp_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [DW-1:0] d; logic lo, hi;
      do_reset();
      check("R1 ready after reset", int'(ry_by_n), 1);
      rd('0, d, lo, hi);
      check("R1 array read", int'(d), 16'hFFFF);
      rd_stat(d);
      check("R1 status after reset", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   task automatic t_bus_ctrl();
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b0; #1;
      check("R2 ce_n high lo", int'(dq_oe_lo), 0);
      check("R2 ce_n high hi", int'(dq_oe_hi), 0);
      ce_n = 1'b0; oe_n = 1'b1; #1;
      check("R2 oe_n high lo", int'(dq_oe_lo), 0);
      oe_n = 1'b0; #1;
      check("R2 both active lo", int'(dq_oe_lo), 1);
      check("R3 word mode hi", int'(dq_oe_hi), 1);
      byte_n = 1'b0; #1;
      check("R3 byte mode hi", int'(dq_oe_hi), 0);
      check("R3 byte mode lo", int'(dq_oe_lo), 1);
      @(negedge clk);
      byte_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic t_ident();
      logic [DW-1:0] d; logic lo, hi;
      wr('0, 8'h90);
      rd(19'h00000, d, lo, hi);
      check("R4 maker id", int'(d), 16'h00B0);
      rd(19'h00001, d, lo, hi);
      check("R4 device id", int'(d), 16'h00EC);
      rd(BLK3 | 19'h2, d, lo, hi);
      check("R4 lock bit clear", int'(d), 0);
      wr('0, 8'h23);
      rd('0, d, lo, hi);
      check("R6 unknown opcode gives array", int'(d), 16'hFFFF);
      // write enable pulse with chip deselected is not a command
      @(negedge clk); cmd_in = 8'h90; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      rd('0, d, lo, hi);
      check("R6 deselected write ignored", int'(d), 16'hFFFF);
   endtask

   task automatic t_program();
      logic [DW-1:0] d; logic lo, hi; int n;
      wr(19'h00100, 8'h40);
      wr(19'h00100, 8'h5A);
      check("R7 busy after program", int'(ry_by_n), 0);
      rd('0, d, lo, hi);
      check("R12 status while busy", int'(d), 16'h0000);
      wr('0, 8'h90);
      wait_ready(n);
      check("R7 program duration", int'(n > T_PROG - 8 && n < T_PROG + 2), 1);
      rd('0, d, lo, hi);
      check("R13 write while busy ignored", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   task automatic t_deselect();
      logic [DW-1:0] d; int n;
      wr('0, 8'h20);
      wr('0, 8'hD0);
      check("R5 busy starts", int'(ry_by_n), 0);
      wait_ready(n);
      check("R5 erase runs while deselected", int'(n > T_ERASE - 6 && n < T_ERASE + 2), 1);
      rd_stat(d);
      check("R5 status after erase", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   task automatic t_bad_confirm();
      logic [DW-1:0] d; logic lo, hi;
      wr('0, 8'h20);
      wr('0, 8'hFF);
      check("R11 no busy", int'(ry_by_n), 1);
      rd('0, d, lo, hi);
      check("R11 back to array", int'(d), 16'hFFFF);
      rd_stat(d);
      check("R11 sequence error status", int'(d), 16'h00B0);
      wr('0, 8'h50);
      rd('0, d, lo, hi);
      check("R12 clear status", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   task automatic t_lock();
      logic [DW-1:0] d; logic lo, hi; int n;
      wr(BLK3, 8'h60);
      wr(BLK3, 8'h01);
      wait_ready(n);
      check("R7 lock set duration", int'(n > T_LOCK - 8 && n < T_LOCK + 2), 1);
      wr('0, 8'h90);
      rd(BLK3 | 19'h2, d, lo, hi);
      check("R4 lock bit set", int'(d), 1);
      rd(BLK2 | 19'h2, d, lo, hi);
      check("R4 other block unlocked", int'(d), 0);
      wp_n = 1'b0;
      wr(BLK3, 8'h40);
      wr(BLK3, 8'h12);
      check("R10 locked program no busy", int'(ry_by_n), 1);
      rd_stat(d);
      check("R10 locked program status", int'(d), 16'h0092);
      wr('0, 8'h50);
      wr(BLK3, 8'h20);
      wr(BLK3, 8'hD0);
      rd_stat(d);
      check("R10 locked erase status", int'(d), 16'h00A2);
      wr('0, 8'h50);
      wp_n = 1'b1;
      wr(BLK3, 8'h20);
      wr(BLK3, 8'hD0);
      check("R10 unprotected erase busy", int'(ry_by_n), 0);
      wait_ready(n);
      rd_stat(d);
      check("R10 unprotected erase status", int'(d), 16'h0080);
      wr('0, 8'h60);
      wr('0, 8'hD0);
      wait_ready(n);
      wr('0, 8'h90);
      rd(BLK3 | 19'h2, d, lo, hi);
      check("R7 lock clear", int'(d), 0);
      wr('0, 8'hFF);
   endtask

   task automatic t_lockout();
      logic [DW-1:0] d;
      wlock = 1'b1;
      wr('0, 8'h40);
      wr('0, 8'h77);
      check("R9 lockout no busy", int'(ry_by_n), 1);
      rd_stat(d);
      check("R9 lockout status", int'(d), 16'h0098);
      wlock = 1'b0;
      wr('0, 8'h50);
      wr('0, 8'hFF);
   endtask

   task automatic t_rp_block();
      logic [DW-1:0] d; logic lo, hi;
      @(negedge clk); rp_n = 1'b0;
      wr('0, 8'h90);
      rd('0, d, lo, hi);
      check("R2 rp_n low bus off", int'(lo), 0);
      @(negedge clk); rp_n = 1'b1;
      rd('0, d, lo, hi);
      check("R9 rp_n low blocks command", int'(d), 16'hFFFF);
   endtask

   task automatic t_glitch();
      logic [DW-1:0] d; int n;
      wr('0, 8'h40);
      wr('0, 8'h33);
      @(negedge clk); rp_n = 1'b0;
      repeat (10) @(negedge clk);
      rp_n = 1'b1;
      check("R8 glitch keeps busy", int'(ry_by_n), 0);
      wait_ready(n);
      check("R8 glitch op finishes", int'(n > 2 && n < T_PROG), 1);
      rd_stat(d);
      check("R8 glitch status", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   task automatic t_abort();
      logic [DW-1:0] d; logic lo, hi; int n;
      bit stayed_low;
      wr(BLK3, 8'h60);
      wr(BLK3, 8'h01);
      wait_ready(n);
      wr('0, 8'h30);
      wr('0, 8'hD0);
      repeat (5) @(negedge clk);
      rp_n = 1'b0;
      stayed_low = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ry_by_n) stayed_low = 1'b0;
      end
      check("R8 busy held through reset", int'(stayed_low), 1);
      rp_n = 1'b1;
      wait_ready(n);
      check("R8 ready soon after release", int'(n < 6), 1);
      rd('0, d, lo, hi);
      check("R1 array after abort", int'(d), 16'hFFFF);
      wr('0, 8'h90);
      rd(BLK3 | 19'h2, d, lo, hi);
      check("R8 locks cleared by reset", int'(d), 0);
      rd_stat(d);
      check("R1 status after abort", int'(d), 16'h0080);
      wr('0, 8'hFF);
   endtask

   initial begin
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; rp_n = 1'b0;
      wp_n = 1'b1; byte_n = 1'b1; wlock = 1'b0;
      addr = '0; cmd_in = '0;
      t_reset_state();
      t_bus_ctrl();
      t_ident();
      t_program();
      t_deselect();
      t_bad_confirm();
      t_lock();
      t_lockout();
      t_rp_block();
      t_glitch();
      t_abort();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule